// File: doc/BRIEF.md
# Prioritised Result Merger with Retry Backpressure

This block collects results from several independent arithmetic pipelines and funnels them into a single result stream. Each source offers a data word and a tag, qualified by a valid bit. By default there are four sources, and their index gives the arithmetic type: 0 is add, 1 is multiply, 2 is square root and 3 is divide. Backpressure runs against the data flow as a *retry* signal. Retry does not mean "ready". It means "this cycle's offer was not taken: hold it and present it again".

Each source port feeds its own one-entry retry buffer, and a second retry buffer drives the merged output. Each buffer is a small state machine with three states. `ST_EMPTY` holds nothing. `ST_ONE` presents one word and acts as a plain register. `ST_FULL` presents one word and also holds a second word in its spare slot, and it drives retry upstream.

The transitions are as follows. EMPTY→ONE happens on a valid input. ONE→EMPTY happens when the word leaves and nothing new arrives. ONE→ONE happens on leave-and-replace, or on a hold with no input. ONE→FULL happens when a valid word arrives while downstream retry is high. FULL→ONE happens when downstream retry drops: the presented word leaves, and the spare word moves forward. FULL→FULL is a hold.

A fixed-priority arbiter passes at most one buffered source word per cycle into the output buffer, with the lowest index winning. It grants nothing while the output buffer is full.

Top module: `result_merger`

## Requirements
- R1: While reset is asserted, `res_valid` is 0 and every bit of `src_retry` is 0.
- R2: A source word offered with its valid bit low is neither stored nor forwarded. Garbage data on an idle source never appears at the output.
- R3: With no retry anywhere, a word accepted at a source port on clock edge t is presented at the output after edge t+1, which is two cycles of latency.
- R4: When several buffered source words wait in the same cycle, the lowest index wins the grant. The order is add (0), then multiply (1), then square root (2), then divide (3).
- R5: At most one word enters the output buffer per cycle. Every accepted source word leaves the output exactly once, and words from any one source leave in the order they were accepted.
- R6: While `res_retry` is high and `res_valid` is high, the presented `res_data` and `res_tag` stay unchanged.
- R7: A buffer that receives a valid word while its downstream retry is high stores that word in its spare slot. It raises its upstream retry in the following cycle.
- R8: While a source's retry is high, its offered word is not taken. Once downstream retry drops, the presented word transfers first. The spare word is presented next, and the retry drops one cycle after that transfer.
- R9: A buffered source word that loses arbitration, or that faces a full output buffer, remains presented unchanged inside its buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | N_SRC | Per-source valid bit |
| src_data | input | N_SRC*DATA_W | Per-source result, source i at bits [i*DATA_W +: DATA_W] |
| src_tag | input | N_SRC*TAG_W | Per-source tag, source i at bits [i*TAG_W +: TAG_W] |
| src_retry | output | N_SRC | Per-source retry: hold the current offer and present it again |
| res_valid | output | 1 | Merged result valid |
| res_data | output | DATA_W | Merged result |
| res_tag | output | TAG_W | Tag of the merged result |
| res_retry | input | 1 | Retry from the consumer of the merged stream |

## Verification
The hardest case to reach is a source buffer in `ST_FULL` whose presented word keeps losing arbitration while the output buffer is itself full. Resolving that case depends on two things in the same cycle: the output retry must drop, and the priority order must finally reach the source. The stimulus builds this up in stages. It first holds the consumer retry high for a long stretch while all four sources offer at full rate, so that every buffer fills. It then releases the retry with random duty. A behavioural queue model is compared against the design on every cycle, and per-source sequence numbers catch any loss, duplication or reordering.

// File: rtl/merge_pkg.sv
package merge_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_FULL  = 2'd2
    } stage_state_e;

    localparam int SRC_ADD  = 0;
    localparam int SRC_MUL  = 1;
    localparam int SRC_SQRT = 2;
    localparam int SRC_DIV  = 3;
endpackage

// File: rtl/retry_stage.sv
module retry_stage
    import merge_pkg::*;
#(
    parameter int W = 74
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_retry,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         in_retry
);
    stage_state_e state_q, state_d;
    logic [W-1:0] main_q, spare_q;
    logic         ld_main_in, ld_main_spare, ld_spare;

    // next state and load controls
    always_comb begin
        state_d       = state_q;
        ld_main_in    = 1'b0;
        ld_main_spare = 1'b0;
        ld_spare      = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) begin
                    ld_main_in = 1'b1;
                    state_d    = ST_ONE;
                end
            end
            ST_ONE: begin
                if (!in_retry) begin
                    ld_main_in = in_valid;
                    state_d    = in_valid ? ST_ONE : ST_EMPTY;
                end else if (in_valid) begin
                    ld_spare = 1'b1;
                    state_d  = ST_FULL;
                end
            end
            ST_FULL: begin
                if (!in_retry) begin
                    ld_main_spare = 1'b1;
                    state_d       = ST_ONE;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // data slots
    always_ff @(posedge clk) begin
        if (ld_main_in)         main_q <= in_data;
        else if (ld_main_spare) main_q <= spare_q;
        if (ld_spare)           spare_q <= in_data;
    end

    // outputs
    always_comb begin
        out_valid = (state_q != ST_EMPTY);
        out_retry = (state_q == ST_FULL);
        out_data  = main_q;
    end

    // R6
    hold_on_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && in_retry |=> out_valid && $stable(out_data));

    // R7
    retry_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_retry) |-> $past(in_retry) && $past(in_valid));

    // R8
    retry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_retry && !in_retry |=> !out_retry && out_valid);
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         block,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        if (!block) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) grant = N'(1) << i;
            end
        end
    end

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    blocked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block |-> grant == '0);

    // R4
    generate
        for (genvar j = 1; j < N; j++) begin : g_prio
            prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant[j] |-> req[j-1:0] == '0);
        end
    endgenerate
endmodule

// File: rtl/result_merger.sv
module result_merger
    import merge_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_valid,
    input  logic [N_SRC*DATA_W-1:0] src_data,
    input  logic [N_SRC*TAG_W-1:0]  src_tag,
    output logic [N_SRC-1:0]        src_retry,
    output logic                    res_valid,
    output logic [DATA_W-1:0]       res_data,
    output logic [TAG_W-1:0]        res_tag,
    input  logic                    res_retry
);
    localparam int PW = DATA_W + TAG_W;

    logic [N_SRC-1:0] st_valid;
    logic [PW-1:0]    st_data [N_SRC];
    logic [N_SRC-1:0] grant;
    logic             out_full;
    logic [PW-1:0]    pick;
    logic [PW-1:0]    res_word;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            retry_stage #(.W(PW)) i_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (src_valid[i]),
                .in_data  ({src_data[i*DATA_W +: DATA_W], src_tag[i*TAG_W +: TAG_W]}),
                .out_retry(src_retry[i]),
                .out_valid(st_valid[i]),
                .out_data (st_data[i]),
                .in_retry (~grant[i])
            );

            // R9
            loser_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_valid[i] && !grant[i] |=> st_valid[i] && $stable(st_data[i]));
        end
    endgenerate

    prio_arbiter #(.N(N_SRC)) i_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (st_valid),
        .block(out_full),
        .grant(grant)
    );

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) pick = pick | st_data[i];
        end
    end

    retry_stage #(.W(PW)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (|grant),
        .in_data  (pick),
        .out_retry(out_full),
        .out_valid(res_valid),
        .out_data (res_word),
        .in_retry (res_retry)
    );

    assign res_data = res_word[PW-1:TAG_W];
    assign res_tag  = res_word[TAG_W-1:0];

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> res_valid);
endmodule

// File: tb/test_result_merger.sv
module test_result_merger;
    localparam int N = 4;
    localparam int DW = 64;
    localparam int TW = 10;
    localparam int PW = DW + TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [N-1:0]    src_valid;
    logic [N*DW-1:0] src_data;
    logic [N*TW-1:0] src_tag;
    logic [N-1:0]    src_retry;
    logic            res_valid;
    logic [DW-1:0]   res_data;
    logic [TW-1:0]   res_tag;
    logic            res_retry;

    result_merger #(.N_SRC(N), .DATA_W(DW), .TAG_W(TW)) i_result_merger (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data), .src_tag(src_tag),
        .src_retry(src_retry),
        .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
        .res_retry(res_retry)
    );

    // producers
    logic          pv   [N];
    logic [DW-1:0] pd   [N];
    logic [TW-1:0] pt   [N];
    int            pseq [N];
    bit            acc  [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            src_valid[i]           = pv[i];
            src_data[i*DW +: DW]   = pd[i];
            src_tag[i*TW +: TW]    = pt[i];
        end
    end

    // behavioural reference: queues
    logic [PW-1:0] iq [N][$];
    logic [PW-1:0] oq [$];
    int vectors = 0;
    int miscompares = 0;
    int accepted = 0;
    int delivered = 0;
    int last_seq [N];
    bit done = 1'b0;

    function automatic logic [DW-1:0] mk_data(int s, int q);
        return {8'(s), 24'(q), 32'hA5A5_0000 | 32'(s)};
    endfunction

    task automatic chk(bit ok, string req, string what, longint got, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // reference step at a clock edge, using pre-edge state
    task automatic model_edge();
        bit ofull;
        bit ifull [N];
        int g;
        logic [PW-1:0] w;
        ofull = (oq.size() == 2);
        for (int i = 0; i < N; i++) ifull[i] = (iq[i].size() == 2);
        if (oq.size() > 0 && !res_retry) void'(oq.pop_front());
        g = -1;
        if (!ofull) begin
            for (int i = 0; i < N; i++) begin
                if (g < 0 && iq[i].size() > 0) g = i;
            end
        end
        if (g >= 0) begin
            w = iq[g].pop_front();
            oq.push_back(w);
        end
        for (int i = 0; i < N; i++) begin
            acc[i] = pv[i] && !ifull[i];
            if (acc[i]) begin
                iq[i].push_back({pd[i], pt[i]});
                accepted++;
            end
        end
    endtask

    task automatic compare_now();
        bit ev;
        ev = (oq.size() > 0);
        // R3 R2: valid timing and no spurious output
        chk(res_valid == ev, "R3", "res_valid", res_valid, ev);
        if (ev && res_valid) begin
            // R4 R5: winner and order
            chk(res_data == oq[0][PW-1:TW], "R4", "res_data", res_data, oq[0][PW-1:TW]);
            chk(res_tag == oq[0][TW-1:0], "R4", "res_tag", res_tag, oq[0][TW-1:0]);
        end
        for (int i = 0; i < N; i++) begin
            // R7 R8: retry timing per source
            chk(src_retry[i] == (iq[i].size() == 2), "R7", "src_retry",
                src_retry[i], iq[i].size() == 2);
        end
    endtask

    task automatic run(int cycles, int rate, int rrate);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_now();
            // R5: order and uniqueness of leaving words, per source
            if (res_valid && !res_retry) begin
                int s, q;
                s = int'(res_data[63:56]);
                q = int'(res_data[55:32]);
                if (s < N) begin
                    chk(q == last_seq[s] + 1, "R5", "sequence", q, last_seq[s] + 1);
                    last_seq[s] = q;
                end else begin
                    chk(1'b0, "R5", "source id", s, 0);
                end
                delivered++;
            end
            for (int i = 0; i < N; i++) begin
                if (!pv[i] || acc[i]) begin
                    if (($urandom % 100) < rate) begin
                        pseq[i]++;
                        pv[i] = 1'b1;
                        pd[i] = mk_data(i, pseq[i]);
                        pt[i] = {2'(i), 8'(pseq[i])};
                    end else begin
                        // R2: garbage on idle sources
                        pv[i] = 1'b0;
                        pd[i] = {$urandom, $urandom};
                        pt[i] = 10'($urandom);
                    end
                end
            end
            res_retry = (($urandom % 100) < rrate);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            pv[i] = 1'b0; pd[i] = '0; pt[i] = '0; pseq[i] = 0; last_seq[i] = 0; acc[i] = 1'b0;
        end
        res_retry = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
        chk(src_retry == '0, "R1", "src_retry in reset", src_retry, 0);
        rst_n = 1'b1;
        run(300, 25, 0);     // sparse, no retry
        run(300, 100, 0);    // saturated: priority
        run(60, 100, 100);   // everything fills
        run(800, 70, 50);
        run(800, 90, 80);
        run(400, 40, 20);
        run(300, 0, 0);      // drain
        // R5: nothing lost or duplicated
        chk(delivered == accepted, "R5", "delivered count", delivered, accepted);
        chk(oq.size() == 0 && res_valid == 1'b0, "R5", "drained", res_valid, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule